// File: doc/BRIEF.md
# TDM Serial Highway Port

This block joins a parallel byte stream to a time-division serial highway. Every frame carries 32 slots of 8 bits, framed by a frame-sync pulse and clocked by an external highway clock. On the transmit side the block takes bytes from a valid/ready stream, one for each slot in slot order, and shifts them out MSB first. On the receive side it assembles serial bits into slot bytes and hands each one out with its slot index on a second valid/ready stream.

Transmit and receive each have their own settings: a frame-sync input, a bit offset from that sync to the first bit of slot 0, the clock edge used to launch or sample bits and the sync, and a rate code that sets the frame length. Each direction has two serial lanes. Per-slot vectors choose the lane, force selected transmit slots to high impedance, and replace selected received slots with an idle code. The highway clock, the sync inputs and the serial inputs pass through synchronisers into the system clock domain. Edges are found there, so one system clock serves both directions and every edge choice.

Back-pressure rules. The transmit stream has a one-byte holding register. `s_tx_ready` is high while that register is empty, except in the cycle when a slot loads. A byte accepted on the stream is bound to the slot shown on `s_tx_slot`. If the register is empty when a slot starts, that slot sends all ones. The receive stream has a single output register. `m_rx_valid` stays high until `m_rx_ready` is seen. A byte that is still waiting when the next slot completes is replaced by that newer byte.

Top module: `tdm_highway_port`

## Requirements
- R1: A frame has 32 slots of 8 bits, sent and received MSB first. Bit position 0 is the selected edge at which the direction's frame sync is sampled high. Slot k bit j sits at position offset + 8k + j, taken modulo the frame length.
- R2: Each direction has its own offset, 0 to 255, so transmit and receive slot windows can be placed independently.
- R3: Edge code 1 selects the rising highway-clock edge and 0 the falling edge. Transmit launches bits on its edge, receive samples bits on its edge, and each direction samples its frame sync on its own edge.
- R4: Rate codes 0, 1 and 2 (2.048, 4.096 and 8.192 Mbit/s) give frames of 256, 512 and 1024 bit periods. Only the first 256 bit periods after the offset carry slots. Outside them both transmit output enables are low.
- R5: Lane-select bit k set to 0 routes slot k to lane A, and set to 1 routes it to lane B. The other lane's output enable stays low for that slot, and receive reads only the selected lane.
- R6: When transmit high-impedance bit k is 1, both transmit output enables are low for all 8 bits of slot k. The slot still uses up its byte from the stream.
- R7: When receive idle bit k is 1, the byte delivered for slot k equals `idle_code` whatever the line carries.
- R8: `s_tx_ready` is high only while the holding register is empty. An accepted byte goes into slot `s_tx_slot`. A slot that starts with the holding register empty transmits 8'hFF.
- R9: Each received slot produces one output byte at its last bit. `m_rx_valid` stays high until it is taken, and a byte not yet taken is overwritten by the next completed slot.
- R10: A frame sync that arrives when the bit counter is not at position 0 restarts the count and sets that direction's sticky alignment flag, which only reset clears.
- R11: Until a direction has seen its first frame sync, it drives no output enable and delivers no byte.
- R12: After reset, all output enables, `m_rx_valid` and both alignment flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the highway clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_clk | input | 1 | Highway bit clock |
| tx_fs | input | 1 | Transmit frame sync |
| rx_fs | input | 1 | Receive frame sync |
| tx_rate | input | 2 | Transmit rate code |
| rx_rate | input | 2 | Receive rate code |
| tx_edge | input | 1 | Transmit edge: 1 rising, 0 falling |
| rx_edge | input | 1 | Receive edge: 1 rising, 0 falling |
| tx_offset | input | 8 | Transmit bit offset |
| rx_offset | input | 8 | Receive bit offset |
| tx_lane_sel | input | 32 | Per-slot transmit lane (1 = B) |
| tx_hiz | input | 32 | Per-slot transmit high impedance |
| rx_lane_sel | input | 32 | Per-slot receive lane (1 = B) |
| rx_idle | input | 32 | Per-slot idle-code substitution |
| idle_code | input | 8 | Substituted receive byte |
| s_tx_valid | input | 1 | Transmit byte valid |
| s_tx_ready | output | 1 | Transmit holding register empty |
| s_tx_data | input | 8 | Transmit byte |
| s_tx_slot | output | 5 | Slot the next accepted byte fills |
| tx_a_d | output | 1 | Lane A serial data |
| tx_a_oe | output | 1 | Lane A output enable |
| tx_b_d | output | 1 | Lane B serial data |
| tx_b_oe | output | 1 | Lane B output enable |
| rx_a | input | 1 | Lane A serial input |
| rx_b | input | 1 | Lane B serial input |
| m_rx_valid | output | 1 | Received byte valid |
| m_rx_ready | input | 1 | Received byte taken |
| m_rx_data | output | 8 | Received byte |
| m_rx_slot | output | 5 | Slot index of received byte |
| tx_align_err | output | 1 | Sticky transmit alignment flag |
| rx_align_err | output | 1 | Sticky receive alignment flag |

## Verification
The bench builds the block with its default parameters: 32 slots, 8-bit slots, an 8-bit offset and two-stage synchronisers. The highway clock runs at one eighth of the system clock. Transmit is looped back to receive through a pull-up model, so every edge pairing and several offsets can be swept at rate 0, and rates 1 and 2 are covered in full frames. From the edge pairing the bench works out the receive offset, the expected byte for every slot and the exact number of output-enable cycles per frame. It also forces an empty transmit stream, a stalled receive stream and a misplaced sync pulse.

// File: rtl/tdmh_pkg.sv
package tdmh_pkg;
  typedef enum logic {EDGE_FALL = 1'b0, EDGE_RISE = 1'b1} edge_e;

  // frame length in bit periods for a rate code; codes above 2 clamp to 2
  function automatic int unsigned frame_bits(input logic [1:0] rate, input int unsigned act_bits);
    case (rate)
      2'd0:    return act_bits;
      2'd1:    return act_bits << 1;
      default: return act_bits << 2;
    endcase
  endfunction
endpackage

// File: rtl/tdmh_sync.sv
module tdmh_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[0] <= '0;
          else        st[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[i] <= '0;
          else        st[i] <= st[i-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/tdmh_slot_timer.sv
module tdmh_slot_timer #(
  parameter int NSLOT     = 32,
  parameter int SLOT_BITS = 8,
  parameter int OFS_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ev,
  input  logic                       fs,
  input  logic [1:0]                 rate,
  input  logic [OFS_W-1:0]           offset,
  output logic                       tick,
  output logic                       active,
  output logic [$clog2(NSLOT)-1:0]   slot,
  output logic [$clog2(SLOT_BITS)-1:0] bitn,
  output logic                       align_err
);
  localparam int ACT   = NSLOT * SLOT_BITS;
  localparam int CNT_W = $clog2(ACT) + 3;
  localparam int SB_W  = $clog2(SLOT_BITS);
  localparam int SL_W  = $clog2(NSLOT);

  logic [CNT_W-1:0] cnt, flen, pos, pos_inc, rel, ofs;
  logic             synced, live;

  always_comb begin
    flen    = CNT_W'(tdmh_pkg::frame_bits(rate, ACT));
    ofs     = CNT_W'(offset);
    pos     = fs ? '0 : cnt;
    pos_inc = pos + 1'b1;
    rel     = (pos >= ofs) ? (pos - ofs) : (pos + flen - ofs);
    live    = synced | fs;
    tick    = ev & live;
    active  = live & (rel < CNT_W'(ACT));
    slot    = rel[SB_W +: SL_W];
    bitn    = rel[SB_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      synced    <= 1'b0;
      align_err <= 1'b0;
    end else if (ev) begin
      cnt <= (pos_inc == flen) ? '0 : pos_inc;
      if (fs) begin
        synced <= 1'b1;
        if (synced && cnt != '0) align_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdmh_tx_lane.sv
module tdmh_tx_lane #(
  parameter int NSLOT     = 32,
  parameter int SLOT_BITS = 8,
  parameter logic [SLOT_BITS-1:0] FILL = '1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         active,
  input  logic [$clog2(NSLOT)-1:0]     slot,
  input  logic [$clog2(SLOT_BITS)-1:0] bitn,
  input  logic [NSLOT-1:0]             lane_sel,
  input  logic [NSLOT-1:0]             hiz,
  input  logic                         s_valid,
  output logic                         s_ready,
  input  logic [SLOT_BITS-1:0]         s_data,
  output logic [$clog2(NSLOT)-1:0]     s_slot,
  output logic                         a_d,
  output logic                         a_oe,
  output logic                         b_d,
  output logic                         b_oe
);
  logic [SLOT_BITS-1:0] hold, sh, cur;
  logic                 full, load, drive;

  always_comb begin
    load    = tick & active & (bitn == '0);
    s_ready = ~full & ~load;
    cur     = load ? (full ? hold : FILL) : sh;
    drive   = active & ~hiz[slot];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold   <= '0;
      full   <= 1'b0;
      sh     <= '0;
      s_slot <= '0;
      a_d    <= 1'b1;
      b_d    <= 1'b1;
      a_oe   <= 1'b0;
      b_oe   <= 1'b0;
    end else begin
      if (s_valid && s_ready) begin
        hold <= s_data;
        full <= 1'b1;
      end
      if (load) begin
        full   <= 1'b0;
        s_slot <= slot + 1'b1;
      end
      if (tick) begin
        if (active) begin
          a_d  <= cur[SLOT_BITS-1];
          b_d  <= cur[SLOT_BITS-1];
          sh   <= {cur[SLOT_BITS-2:0], 1'b0};
          a_oe <= drive & ~lane_sel[slot];
          b_oe <= drive &  lane_sel[slot];
        end else begin
          a_oe <= 1'b0;
          b_oe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tdmh_rx_lane.sv
module tdmh_rx_lane #(
  parameter int NSLOT     = 32,
  parameter int SLOT_BITS = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         active,
  input  logic [$clog2(NSLOT)-1:0]     slot,
  input  logic [$clog2(SLOT_BITS)-1:0] bitn,
  input  logic                         din_a,
  input  logic                         din_b,
  input  logic [NSLOT-1:0]             lane_sel,
  input  logic [NSLOT-1:0]             idle,
  input  logic [SLOT_BITS-1:0]         idle_code,
  output logic                         m_valid,
  input  logic                         m_ready,
  output logic [SLOT_BITS-1:0]         m_data,
  output logic [$clog2(NSLOT)-1:0]     m_slot
);
  localparam int SB_W = $clog2(SLOT_BITS);

  logic [SLOT_BITS-1:0] sh, nxt;
  logic                 bitv, take, last;

  always_comb begin
    bitv = lane_sel[slot] ? din_b : din_a;
    nxt  = {sh[SLOT_BITS-2:0], bitv};
    take = tick & active;
    last = (bitn == SB_W'(SLOT_BITS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
      m_slot  <= '0;
    end else begin
      if (take) sh <= nxt;
      if (take && last) begin
        m_valid <= 1'b1;
        m_data  <= idle[slot] ? idle_code : nxt;
        m_slot  <= slot;
      end else if (m_valid && m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdm_highway_port.sv
module tdm_highway_port #(
  parameter int NSLOT       = 32,
  parameter int SLOT_BITS   = 8,
  parameter int OFS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         hw_clk,
  input  logic                         tx_fs,
  input  logic                         rx_fs,
  input  logic [1:0]                   tx_rate,
  input  logic [1:0]                   rx_rate,
  input  logic                         tx_edge,
  input  logic                         rx_edge,
  input  logic [OFS_W-1:0]             tx_offset,
  input  logic [OFS_W-1:0]             rx_offset,
  input  logic [NSLOT-1:0]             tx_lane_sel,
  input  logic [NSLOT-1:0]             tx_hiz,
  input  logic [NSLOT-1:0]             rx_lane_sel,
  input  logic [NSLOT-1:0]             rx_idle,
  input  logic [SLOT_BITS-1:0]         idle_code,
  input  logic                         s_tx_valid,
  output logic                         s_tx_ready,
  input  logic [SLOT_BITS-1:0]         s_tx_data,
  output logic [$clog2(NSLOT)-1:0]     s_tx_slot,
  output logic                         tx_a_d,
  output logic                         tx_a_oe,
  output logic                         tx_b_d,
  output logic                         tx_b_oe,
  input  logic                         rx_a,
  input  logic                         rx_b,
  output logic                         m_rx_valid,
  input  logic                         m_rx_ready,
  output logic [SLOT_BITS-1:0]         m_rx_data,
  output logic [$clog2(NSLOT)-1:0]     m_rx_slot,
  output logic                         tx_align_err,
  output logic                         rx_align_err
);
  import tdmh_pkg::*;

  localparam int SL_W = $clog2(NSLOT);
  localparam int SB_W = $clog2(SLOT_BITS);

  logic [4:0] pins_s;
  logic       hclk_d, rise, fall, tx_ev, rx_ev;

  tdmh_sync #(.W(5), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({rx_b, rx_a, rx_fs, tx_fs, hw_clk}),
    .q(pins_s)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hclk_d <= 1'b0;
    else        hclk_d <= pins_s[0];

  always_comb begin
    rise  = pins_s[0] & ~hclk_d;
    fall  = ~pins_s[0] & hclk_d;
    tx_ev = (edge_e'(tx_edge) == EDGE_RISE) ? rise : fall;
    rx_ev = (edge_e'(rx_edge) == EDGE_RISE) ? rise : fall;
  end

  logic            tx_tick, tx_act, rx_tick, rx_act;
  logic [SL_W-1:0] tx_slot_i, rx_slot_i;
  logic [SB_W-1:0] tx_bit_i, rx_bit_i;

  tdmh_slot_timer #(.NSLOT(NSLOT), .SLOT_BITS(SLOT_BITS), .OFS_W(OFS_W)) u_tx_tmr (
    .clk(clk), .rst_n(rst_n), .ev(tx_ev), .fs(pins_s[1]),
    .rate(tx_rate), .offset(tx_offset),
    .tick(tx_tick), .active(tx_act), .slot(tx_slot_i), .bitn(tx_bit_i),
    .align_err(tx_align_err)
  );

  tdmh_slot_timer #(.NSLOT(NSLOT), .SLOT_BITS(SLOT_BITS), .OFS_W(OFS_W)) u_rx_tmr (
    .clk(clk), .rst_n(rst_n), .ev(rx_ev), .fs(pins_s[2]),
    .rate(rx_rate), .offset(rx_offset),
    .tick(rx_tick), .active(rx_act), .slot(rx_slot_i), .bitn(rx_bit_i),
    .align_err(rx_align_err)
  );

  tdmh_tx_lane #(.NSLOT(NSLOT), .SLOT_BITS(SLOT_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .tick(tx_tick), .active(tx_act), .slot(tx_slot_i), .bitn(tx_bit_i),
    .lane_sel(tx_lane_sel), .hiz(tx_hiz),
    .s_valid(s_tx_valid), .s_ready(s_tx_ready), .s_data(s_tx_data), .s_slot(s_tx_slot),
    .a_d(tx_a_d), .a_oe(tx_a_oe), .b_d(tx_b_d), .b_oe(tx_b_oe)
  );

  tdmh_rx_lane #(.NSLOT(NSLOT), .SLOT_BITS(SLOT_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .tick(rx_tick), .active(rx_act), .slot(rx_slot_i), .bitn(rx_bit_i),
    .din_a(pins_s[3]), .din_b(pins_s[4]),
    .lane_sel(rx_lane_sel), .idle(rx_idle), .idle_code(idle_code),
    .m_valid(m_rx_valid), .m_ready(m_rx_ready), .m_data(m_rx_data), .m_slot(m_rx_slot)
  );
endmodule

// File: rtl/tdmh_checker.sv
module tdmh_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_a_oe,
  input logic tx_b_oe,
  input logic s_tx_valid,
  input logic s_tx_ready,
  input logic m_rx_valid,
  input logic m_rx_ready,
  input logic tx_align_err,
  input logic rx_align_err
);
  assert_one_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_a_oe, tx_b_oe}));

  assert_hold_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tx_valid && s_tx_ready) |=> !s_tx_ready);

  assert_rx_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rx_valid && !m_rx_ready) |=> m_rx_valid);

  assert_tx_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_align_err |=> tx_align_err);

  assert_rx_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_align_err |=> rx_align_err);
endmodule

bind tdm_highway_port tdmh_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_a_oe(tx_a_oe), .tx_b_oe(tx_b_oe),
  .s_tx_valid(s_tx_valid), .s_tx_ready(s_tx_ready),
  .m_rx_valid(m_rx_valid), .m_rx_ready(m_rx_ready),
  .tx_align_err(tx_align_err), .rx_align_err(rx_align_err)
);

// File: tb/sim_tdm_highway_port.sv
`timescale 1ns/1ps
module sim_tdm_highway_port;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [1:0]  rate;
  logic        tx_edge, rx_edge;
  logic [7:0]  tx_off, rx_off;
  logic [31:0] tx_lane, tx_hiz, rx_lane, rx_idle;
  logic [7:0]  idle_code;
  logic        tx_supply, m_ready;
  logic        s_tx_ready, tx_a_d, tx_a_oe, tx_b_d, tx_b_oe;
  logic [4:0]  s_tx_slot, m_rx_slot;
  logic        m_rx_valid, tx_err, rx_err;
  logic [7:0]  m_rx_data, s_tx_data;
  logic        rx_a, rx_b, hw_clk, fs;

  int checks = 0, fails = 0;
  bit done = 0;

  // highway clock / frame sync generator, changing on the falling system edge
  bit gen_en = 0, fs_en = 0, inject = 0;
  int ph = 0, per = 0, flen = 256;
  always @(negedge clk) begin
    if (!gen_en) begin ph <= 0; per <= 0; end
    else if (ph == 7) begin ph <= 0; per <= (per >= flen - 1) ? 0 : per + 1; end
    else ph <= ph + 1;
  end
  assign hw_clk = gen_en && ph < 4;
  assign fs = fs_en && (((per == flen - 1) && ph >= 2) || (per == 0 && ph < 2) ||
                        (inject && ((per == 100 && ph >= 2) || (per == 101 && ph < 2))));

  function automatic logic [7:0] pat(input int s);
    return 8'((s * 11 + 3) & 8'h7F);
  endfunction

  assign s_tx_data = pat(int'(s_tx_slot));
  assign rx_a = tx_a_oe ? tx_a_d : 1'b1;
  assign rx_b = tx_b_oe ? tx_b_d : 1'b1;

  tdm_highway_port u0 (
    .clk(clk), .rst_n(rst_n), .hw_clk(hw_clk), .tx_fs(fs), .rx_fs(fs),
    .tx_rate(rate), .rx_rate(rate), .tx_edge(tx_edge), .rx_edge(rx_edge),
    .tx_offset(tx_off), .rx_offset(rx_off),
    .tx_lane_sel(tx_lane), .tx_hiz(tx_hiz), .rx_lane_sel(rx_lane), .rx_idle(rx_idle),
    .idle_code(idle_code),
    .s_tx_valid(tx_supply), .s_tx_ready(s_tx_ready), .s_tx_data(s_tx_data), .s_tx_slot(s_tx_slot),
    .tx_a_d(tx_a_d), .tx_a_oe(tx_a_oe), .tx_b_d(tx_b_d), .tx_b_oe(tx_b_oe),
    .rx_a(rx_a), .rx_b(rx_b),
    .m_rx_valid(m_rx_valid), .m_rx_ready(m_ready), .m_rx_data(m_rx_data), .m_rx_slot(m_rx_slot),
    .tx_align_err(tx_err), .rx_align_err(rx_err)
  );

  // monitors
  bit clr = 0;
  int oe_any = 0, oe_a = 0, nrx = 0;
  logic [7:0] got [32];
  bit seen [32];
  always @(posedge clk) begin
    if (clr) begin
      oe_any <= 0; oe_a <= 0; nrx <= 0;
      for (int i = 0; i < 32; i++) seen[i] <= 0;
    end else begin
      if (tx_a_oe || tx_b_oe) oe_any <= oe_any + 1;
      if (tx_a_oe) oe_a <= oe_a + 1;
      if (m_rx_valid && m_ready) begin
        got[m_rx_slot] <= m_rx_data;
        seen[m_rx_slot] <= 1;
        nrx <= nrx + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expb(input int s, input bit fill);
    if (rx_idle[s]) return idle_code;                         // R7
    if (tx_hiz[s] || (rx_lane[s] != tx_lane[s])) return 8'hFF; // R6, R5
    if (fill) return 8'hFF;                                    // R8
    return pat(s);
  endfunction

  task automatic clear_mon();
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
  endtask

  task automatic check_frame(input bit fill, input string tag);
    int ea, eany;
    clear_mon();
    repeat (flen * 8) @(negedge clk);
    eany = 0; ea = 0;
    for (int s = 0; s < 32; s++) begin
      if (!tx_hiz[s]) begin eany += 64; if (!tx_lane[s]) ea += 64; end
    end
    chk(oe_any == eany, {tag, " R4 R6 enable cycles"}, oe_any, eany);
    chk(oe_a == ea, {tag, " R5 lane A cycles"}, oe_a, ea);
    for (int s = 0; s < 32; s++)
      chk(seen[s] && got[s] == expb(s, fill), {tag, " R1 R2 R3 slot byte"},
          seen[s] ? int'(got[s]) : -1, int'(expb(s, fill)));
    chk(!tx_err && !rx_err, {tag, " R10 no alignment error"}, {tx_err, rx_err}, 0);
  endtask

  task automatic run_cfg(input int r, input bit te, input bit re, input int toff, input bit first);
    @(negedge clk);
    rst_n = 0; gen_en = 0; fs_en = 0; inject = 0;
    rate = 2'(r); tx_edge = te; rx_edge = re;
    tx_off = 8'(toff);
    rx_off = (!te && re) ? 8'(toff) : 8'(toff + 1);
    flen = 256 << r;
    repeat (3) @(negedge clk);
    if (first) begin
      chk(!tx_a_oe && !tx_b_oe, "R12 enables low in reset", {tx_a_oe, tx_b_oe}, 0);
      chk(!m_rx_valid, "R12 rx valid low in reset", m_rx_valid, 0);
      chk(!tx_err && !rx_err, "R12 flags low in reset", {tx_err, rx_err}, 0);
    end
    rst_n = 1;
    gen_en = 1;
    if (first) begin
      clear_mon();
      repeat (64 * 8) @(negedge clk);
      chk(oe_any == 0, "R11 no enable before sync", oe_any, 0);
      chk(nrx == 0, "R11 no byte before sync", nrx, 0);
    end
    fs_en = 1;
    repeat (3 * flen * 8) @(negedge clk);
    check_frame(0, $sformatf("rate%0d te%0d re%0d off%0d", r, te, re, toff));
  endtask

  initial begin
    rst_n = 0; rate = 0; tx_edge = 1; rx_edge = 1; tx_off = 0; rx_off = 0;
    tx_lane   = 32'h0F0F_00A5;
    tx_hiz    = 32'h0000_0410;
    rx_lane   = 32'h0F0F_00A5 ^ (32'h1 << 20);
    rx_idle   = 32'h0002_0008;
    idle_code = 8'hC3;
    tx_supply = 1; m_ready = 1;

    run_cfg(0, 1, 1, 0, 1);
    for (int te = 0; te < 2; te++)
      for (int re = 0; re < 2; re++)
        run_cfg(0, te[0], re[0], 131, 0);   // R3 every edge pairing, R2 offset
    run_cfg(0, 0, 1, 0, 0);
    run_cfg(1, 1, 0, 200, 0);              // R4 rate 1
    run_cfg(2, 0, 0, 77, 0);               // R4 rate 2
    run_cfg(0, 1, 0, 5, 0);

    // R8: empty transmit stream sends all ones
    tx_supply = 0;
    repeat (2 * flen * 8) @(negedge clk);
    check_frame(1, "R8 empty stream");
    tx_supply = 1;
    repeat (2 * flen * 8) @(negedge clk);

    // R9: stalled receive stream keeps a valid, up-to-date byte
    m_ready = 0;
    repeat (300) @(negedge clk);
    chk(m_rx_valid, "R9 valid held while stalled", m_rx_valid, 1);
    chk(m_rx_data == expb(int'(m_rx_slot), 0), "R9 newest byte kept",
        m_rx_data, expb(int'(m_rx_slot), 0));
    m_ready = 1;

    // R10: misplaced sync pulse
    @(negedge clk) inject = 1;
    repeat (flen * 8) @(negedge clk);
    inject = 0;
    chk(tx_err, "R10 tx alignment flag", tx_err, 1);
    chk(rx_err, "R10 rx alignment flag", rx_err, 1);
    repeat (flen * 8) @(negedge clk);
    chk(tx_err && rx_err, "R10 flags sticky", {tx_err, rx_err}, 3);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 195000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule